// File: doc/BRIEF.md
# Stacked-Board SPI Command Decoder

This block is the serial front end of one waveform board in a stack of up to fifteen boards. All the boards listen on one shared SPI bus (mode 0, most significant bit first). The block runs on the board's system clock. It oversamples the serial clock, chip select and data lines through a synchronizer and parses the byte stream in that clock domain. Every transaction opens with a command byte. That byte names a target board, says whether the target is a register or a waveform memory, picks which one, and says whether the access is a read or a write.

A board acts on a write when the board field equals its strapped 4-bit identity or the broadcast code 15. It answers a read only when the field equals its own identity. Three 8-bit registers can be written and read back: configuration, checksum and frame select. Memory writes carry a 16-bit start address and then any number of 16-bit words. Each word goes to the next location of the selected channel memory. A registered read port lets the playback logic fetch all three channels at one address.

The configuration register holds these controls:
- a self-clearing board reset;
- a clock-doubling control;
- a waveform enable;
- a software trigger, which is ORed with an external trigger input;
- a select for the auxiliary output pin, which carries either the serial read data or a masked OR of three channel bits.

Top module: `spi_stack_node`

## Requirements
- R1: The command byte is decoded as bits [1:0] = select, bit 2 = memory flag, bits [6:3] = board field, bit 7 = write. A write is applied when the board field equals `board_id` or 15. Writes that carry any other board field change nothing.
- R2: A register write is the command byte plus one data byte. Select 0 is configuration, 1 is checksum (`crc_val`) and 2 is frame select (`frame_sel`). All three reset to 0.
- R3: A register read is answered only when the board field equals `board_id`. The 8-bit value is sent MSB first, and each bit is valid before the SCK rising edge that samples it, the first bit before the first rising edge after the command. Select 3 reads as 0, and writes to select 3 change nothing.
- R4: `spi_miso` is 0 while chip select is high and during any read that this board does not answer, broadcast reads included.
- R5: Configuration bit 0 produces exactly one `board_rst` pulse of one clock and reads back as 0.
- R6: Configuration bit 1 drives `clk_dbl` and bit 2 drives `wave_en`. `trig` equals configuration bit 3 ORed with `ttl_trig`, registered once.
- R7: When configuration bit 4 is 1, `aux_out` follows `spi_miso`. When it is 0, `aux_out` is the OR over i of `chan_bits[i]` AND configuration bit 5+i. Both cases have one clock of latency.
- R8: A memory write is the command byte (memory flag 1, select 0..2 = channel), then the start address low byte and then high byte, then 16-bit words sent MSB first. These words are stored at successive addresses.
- R9: Only the low AW bits of the start address are used, and the write address wraps from 2^AW-1 to 0.
- R10: A rising edge of chip select ends the transaction. A partially received data byte or word is discarded, and the next transaction starts with a command byte.
- R11: Memory commands with select 3, and memory read commands, change no memory and leave `spi_miso` at 0.
- R12: `pb_data` returns all channels' words at `pb_addr` one clock after the address is presented, with channel i in bits [16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | 4 | Strapped board identity |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| ttl_trig | input | 1 | External trigger input |
| chan_bits | input | 3 | One status bit per channel for the auxiliary pin |
| pb_addr | input | AW | Playback read address |
| spi_miso | output | 1 | Serial read data, 0 when not answering |
| aux_out | output | 1 | Auxiliary pin: read data or masked channel OR |
| board_rst | output | 1 | One-clock board reset pulse |
| clk_dbl | output | 1 | Clock doubling control |
| wave_en | output | 1 | Waveform enable |
| trig | output | 1 | Effective trigger |
| frame_sel | output | 8 | Frame select register |
| crc_val | output | 8 | Checksum register |
| pb_data | output | 48 | Words of the three channels at `pb_addr` |

## Verification
The hardest situation to reach from the ports is a transaction that chip select cuts off partway through a data byte or a memory word. The bench builds it with a bit-count-controlled transfer task. That task stops after a chosen number of clocks in the middle of a word, or after a full first word and part of a second, and then raises chip select. The bench then sweeps the whole memory through the playback port against its own model, and it follows with a complete register write to show that the parser restarted at a command byte. Address wrap is reached with a start address whose discarded upper bits are all ones, in a small build with a 16-word memory.

// File: rtl/spn_pkg.sv
package spn_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int NCH    = 3;
  localparam logic [3:0] BCAST_ID = 4'hF;

  localparam logic [1:0] RA_CFG = 2'd0;
  localparam logic [1:0] RA_CRC = 2'd1;
  localparam logic [1:0] RA_FRM = 2'd2;

  localparam int CFG_RST  = 0;
  localparam int CFG_X2   = 1;
  localparam int CFG_EN   = 2;
  localparam int CFG_TRG  = 3;
  localparam int CFG_AUX  = 4;
  localparam int CFG_MSK  = 5;

  typedef struct packed {
    logic       wr;
    logic [3:0] board;
    logic       is_mem;
    logic [1:0] sel;
  } cmd_t;

  typedef enum logic [2:0] {
    P_CMD, P_REGWR, P_REGRD, P_ALO, P_AHI, P_DATA, P_SKIP
  } pstate_t;
endpackage

// File: rtl/spn_sync.sv
module spn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  logic [STAGES:0]   sck_p;
  logic [TOP:0]      csn_p;
  logic [TOP:0]      mosi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[TOP:0], sck};
      csn_p  <= (STAGES > 1) ? {csn_p[TOP:0], csn} >> 0 : {csn_p, csn} >> 0;
      mosi_p <= {mosi_p[TOP:0], mosi} >> 0;
    end
  end

  assign sck_rise = sck_p[TOP] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[TOP] & sck_p[STAGES];
  assign cs_act   = ~csn_p[TOP];
  assign mosi_s   = mosi_p[TOP];
endmodule

// File: rtl/spn_parser.sv
module spn_parser
  import spn_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        board_id,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_val,
  output logic [1:0]        rd_sel,
  output logic              reg_we,
  output logic [1:0]        reg_wa,
  output logic [BYTE_W-1:0] reg_wd,
  output logic              mem_we,
  output logic [1:0]        mem_sel,
  output logic [AW-1:0]     mem_wa,
  output logic [WORD_W-1:0] mem_wd,
  output logic              miso
);
  pstate_t           st;
  logic [WORD_W-2:0] sh;
  logic [3:0]        bitcnt;
  logic [2:0]        rd_cnt;
  logic [BYTE_W-1:0] txsh;
  logic [BYTE_W-1:0] lo_q;
  logic [AW-1:0]     waddr;
  logic [BYTE_W-1:0] byte_in;
  logic              byte_done;
  logic              hit_wr;
  logic              hit_rd;
  cmd_t              c;

  assign byte_in   = {sh[BYTE_W-2:0], mosi_s};
  assign c         = cmd_t'(byte_in);
  assign byte_done = (bitcnt[2:0] == 3'd7);
  assign hit_wr    = (c.board == board_id) || (c.board == BCAST_ID);
  assign hit_rd    = (c.board == board_id) && (c.board != BCAST_ID);
  assign rd_sel    = c.sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= P_CMD;
      sh      <= '0;
      bitcnt  <= '0;
      rd_cnt  <= '0;
      txsh    <= '0;
      lo_q    <= '0;
      waddr   <= '0;
      reg_we  <= 1'b0;
      reg_wa  <= '0;
      reg_wd  <= '0;
      mem_we  <= 1'b0;
      mem_sel <= '0;
      mem_wa  <= '0;
      mem_wd  <= '0;
      miso    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      mem_we <= 1'b0;
      if (!cs_act) begin
        st     <= P_CMD;
        bitcnt <= '0;
        rd_cnt <= '0;
        txsh   <= '0;
        miso   <= 1'b0;
      end else begin
        miso <= (st == P_REGRD) ? txsh[BYTE_W-1] : 1'b0;
        if (sck_fall && st == P_REGRD && rd_cnt != 3'd0)
          txsh <= {txsh[BYTE_W-2:0], 1'b0};
        if (sck_rise) begin
          sh     <= {sh[WORD_W-3:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
          case (st)
            P_CMD: if (byte_done) begin
              bitcnt <= '0;
              if (!c.is_mem && c.wr && hit_wr) begin
                st     <= P_REGWR;
                reg_wa <= c.sel;
              end else if (!c.is_mem && !c.wr && hit_rd) begin
                st     <= P_REGRD;
                txsh   <= rd_val;
                rd_cnt <= '0;
              end else if (c.is_mem && c.wr && hit_wr && c.sel != 2'd3) begin
                st      <= P_ALO;
                mem_sel <= c.sel;
              end else begin
                st <= P_SKIP;
              end
            end
            P_REGWR: if (byte_done) begin
              bitcnt <= '0;
              reg_we <= 1'b1;
              reg_wd <= byte_in;
              st     <= P_SKIP;
            end
            P_REGRD: begin
              rd_cnt <= rd_cnt + 1'b1;
              if (rd_cnt == 3'd7) st <= P_SKIP;
            end
            P_ALO: if (byte_done) begin
              bitcnt <= '0;
              lo_q   <= byte_in;
              st     <= P_AHI;
            end
            P_AHI: if (byte_done) begin
              bitcnt <= '0;
              waddr  <= AW'({byte_in, lo_q});
              st     <= P_DATA;
            end
            P_DATA: if (bitcnt == 4'd15) begin
              bitcnt <= '0;
              mem_we <= 1'b1;
              mem_wa <= waddr;
              mem_wd <= {sh, mosi_s};
              waddr  <= waddr + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso); // R4
  AST_MEM_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (waddr == AW'(mem_wa + 1'b1))); // R9
endmodule

// File: rtl/spn_regs.sv
module spn_regs
  import spn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        wa,
  input  logic [BYTE_W-1:0] wd,
  input  logic [1:0]        rd_sel,
  input  logic              ttl_trig,
  input  logic [NCH-1:0]    chan_bits,
  input  logic              miso,
  output logic [BYTE_W-1:0] rd_val,
  output logic              board_rst,
  output logic              clk_dbl,
  output logic              wave_en,
  output logic              trig,
  output logic [BYTE_W-1:0] frame_sel,
  output logic [BYTE_W-1:0] crc_val,
  output logic              aux_out
);
  logic [BYTE_W-1:1] cfg_q;
  logic [NCH-1:0]    mask;

  assign mask    = cfg_q[CFG_MSK+NCH-1:CFG_MSK];
  assign clk_dbl = cfg_q[CFG_X2];
  assign wave_en = cfg_q[CFG_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      board_rst <= 1'b0;
      frame_sel <= '0;
      crc_val   <= '0;
      trig      <= 1'b0;
      aux_out   <= 1'b0;
    end else begin
      board_rst <= 1'b0;
      if (we) begin
        case (wa)
          RA_CFG: begin
            cfg_q     <= wd[BYTE_W-1:1];
            board_rst <= wd[CFG_RST];
          end
          RA_CRC:  crc_val   <= wd;
          RA_FRM:  frame_sel <= wd;
          default: ;
        endcase
      end
      trig    <= cfg_q[CFG_TRG] | ttl_trig;
      aux_out <= cfg_q[CFG_AUX] ? miso : |(chan_bits & mask);
    end
  end

  always_comb begin
    case (rd_sel)
      RA_CFG:  rd_val = {cfg_q, 1'b0};
      RA_CRC:  rd_val = crc_val;
      RA_FRM:  rd_val = frame_sel;
      default: rd_val = '0;
    endcase
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    board_rst |=> !board_rst); // R5
  AST_TRIG_OR: assert property (@(posedge clk) disable iff (rst)
    ttl_trig |=> trig); // R6
  AST_AUX_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[CFG_AUX] && ((chan_bits & mask) == '0)) |=> !aux_out); // R7
endmodule

// File: rtl/spn_wavemem.sv
module spn_wavemem
  import spn_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [1:0]            sel,
  input  logic [AW-1:0]         wa,
  input  logic [WORD_W-1:0]     wd,
  input  logic [AW-1:0]         ra,
  output logic [NCH*WORD_W-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rq;
    always_ff @(posedge clk) begin
      if (we && sel == 2'(g)) mem[wa] <= wd;
      rq <= mem[ra];
    end
    assign rd[g*WORD_W +: WORD_W] = rq;
  end
endmodule

// File: rtl/spi_stack_node.sv
module spi_stack_node
  import spn_pkg::*;
#(
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            board_id,
  input  logic                  spi_sck,
  input  logic                  spi_csn,
  input  logic                  spi_mosi,
  input  logic                  ttl_trig,
  input  logic [2:0]            chan_bits,
  input  logic [AW-1:0]         pb_addr,
  output logic                  spi_miso,
  output logic                  aux_out,
  output logic                  board_rst,
  output logic                  clk_dbl,
  output logic                  wave_en,
  output logic                  trig,
  output logic [7:0]            frame_sel,
  output logic [7:0]            crc_val,
  output logic [NCH*WORD_W-1:0] pb_data
);
  logic              sck_rise, sck_fall, cs_act, mosi_s;
  logic [1:0]        rd_sel;
  logic [BYTE_W-1:0] rd_val;
  logic              reg_we;
  logic [1:0]        reg_wa;
  logic [BYTE_W-1:0] reg_wd;
  logic              mem_we;
  logic [1:0]        mem_sel;
  logic [AW-1:0]     mem_wa;
  logic [WORD_W-1:0] mem_wd;

  spn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spn_parser #(.AW(AW)) u_parser (
    .clk(clk), .rst(rst), .board_id(board_id),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s),
    .rd_val(rd_val), .rd_sel(rd_sel),
    .reg_we(reg_we), .reg_wa(reg_wa), .reg_wd(reg_wd),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_wa(mem_wa), .mem_wd(mem_wd),
    .miso(spi_miso)
  );

  spn_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wa(reg_wa), .wd(reg_wd),
    .rd_sel(rd_sel), .ttl_trig(ttl_trig), .chan_bits(chan_bits), .miso(spi_miso),
    .rd_val(rd_val), .board_rst(board_rst), .clk_dbl(clk_dbl), .wave_en(wave_en),
    .trig(trig), .frame_sel(frame_sel), .crc_val(crc_val), .aux_out(aux_out)
  );

  spn_wavemem #(.AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .sel(mem_sel), .wa(mem_wa), .wd(mem_wd),
    .ra(pb_addr), .rd(pb_data)
  );
endmodule

// File: tb/spi_stack_node_tb.sv
module spi_stack_node_tb;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 6;
  localparam logic [3:0] ME = 4'd5;

  logic clk = 0, rst = 1;
  logic spi_sck = 0, spi_csn = 1, spi_mosi = 0, ttl_trig = 0;
  logic [2:0] chan_bits = 0;
  logic [AW-1:0] pb_addr = 0;
  logic spi_miso, aux_out, board_rst, clk_dbl, wave_en, trig;
  logic [7:0] frame_sel, crc_val;
  logic [47:0] pb_data;

  int vecs = 0, errs = 0, rst_cnt = 0;
  logic [15:0] exp_mem [3][DEPTH];
  logic [7:0] exp_frm = 0, exp_crc = 0, aux_cap;

  always #2.5 clk = ~clk;

  spi_stack_node #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .board_id(ME), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .ttl_trig(ttl_trig), .chan_bits(chan_bits), .pb_addr(pb_addr),
    .spi_miso(spi_miso), .aux_out(aux_out), .board_rst(board_rst), .clk_dbl(clk_dbl),
    .wave_en(wave_en), .trig(trig), .frame_sel(frame_sel), .crc_val(crc_val),
    .pb_data(pb_data)
  );

  always @(negedge clk) if (board_rst) rst_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vecs++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 0;
    for (int i = 7; i >= 8 - nb; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      aux_cap[i] = aux_out;
      spi_sck = 1;
      repeat (HALF) @(negedge clk);
      spi_sck = 0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); spi_csn = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_csn = 1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] cmd(input logic wr, input logic [3:0] b,
                                      input logic m, input logic [1:0] s);
    return {wr, b, m, s};
  endfunction

  task automatic reg_wr(input logic [3:0] b, input logic [1:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_lo(); xfer(cmd(1, b, 0, a), 8, r); xfer(d, 8, r); cs_hi();
    if (b == ME || b == 4'hF) begin
      if (a == 2'd1) exp_crc = d;
      if (a == 2'd2) exp_frm = d;
    end
  endtask

  task automatic reg_rd(input logic [3:0] b, input logic [1:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_lo(); xfer(cmd(0, b, 0, a), 8, r); xfer(8'h00, 8, d); cs_hi();
  endtask

  function automatic logic [15:0] pat(input int seed, input int i);
    return 16'((seed * 16'h1357) ^ (i * 16'h0B0D) ^ 16'hA5C3);
  endfunction

  task automatic mem_wr(input logic [3:0] b, input logic [1:0] ch, input logic [15:0] start,
                        input int n, input int seed);
    logic [7:0] r;
    logic [15:0] w;
    cs_lo();
    xfer(cmd(1, b, 1, ch), 8, r);
    xfer(start[7:0], 8, r);
    xfer(start[15:8], 8, r);
    for (int i = 0; i < n; i++) begin
      w = pat(seed, i);
      xfer(w[15:8], 8, r); xfer(w[7:0], 8, r);
      if ((b == ME || b == 4'hF) && ch != 2'd3)
        exp_mem[ch][AW'(start + 16'(i))] = w;
    end
    cs_hi();
  endtask

  task automatic cmp_mem(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); pb_addr = AW'(a);
      @(negedge clk);
      for (int c = 0; c < 3; c++)
        chk(req, {16'h0, pb_data[c*16 +: 16]}, {16'h0, exp_mem[c][a]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] rv, r;
    logic [15:0] old;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // reset state: R2, R4, R6
    chk("R2 frame reset", frame_sel, 0);
    chk("R2 crc reset", crc_val, 0);
    chk("R6 cfg outputs reset", {clk_dbl, wave_en, trig, board_rst}, 0);
    chk("R4 miso idle", spi_miso, 0);

    // R8 + R1: broadcast fill of every channel
    for (int c = 0; c < 3; c++) mem_wr(4'hF, 2'(c), 16'h0000, DEPTH, c + 1);
    cmp_mem("R8 broadcast fill");

    // R1: board field sweep
    for (int b = 0; b < 16; b++) begin
      old = {8'h0, exp_frm};
      reg_wr(4'(b), 2'd2, 8'(8'h40 + b));
      chk("R1 board filter", frame_sel, exp_frm);
      if (b != 5 && b != 15) chk("R1 other board ignored", frame_sel, old);
    end

    // R2 / R3: write and read back checksum and frame
    for (int v = 0; v < 16; v++) begin
      reg_wr(ME, 2'd1, 8'(v * 17 ^ 8'h5A));
      reg_wr(ME, 2'd2, ~8'(v * 17 ^ 8'h5A));
      chk("R2 crc write", crc_val, exp_crc);
      chk("R2 frame write", frame_sel, exp_frm);
      reg_rd(ME, 2'd1, rv); chk("R3 crc read", rv, exp_crc);
      reg_rd(ME, 2'd2, rv); chk("R3 frame read", rv, exp_frm);
    end

    // R3: select 3
    reg_wr(ME, 2'd3, 8'hFF);
    chk("R3 sel3 write no frame", frame_sel, exp_frm);
    chk("R3 sel3 write no crc", crc_val, exp_crc);
    reg_rd(ME, 2'd0, rv); chk("R3 sel3 write no cfg", rv, 0);
    reg_rd(ME, 2'd3, rv); chk("R3 sel3 reads 0", rv, 0);

    // R4: broadcast and foreign reads
    reg_wr(ME, 2'd2, 8'hFF);
    reg_rd(4'hF, 2'd2, rv); chk("R4 broadcast read silent", rv, 0);
    reg_rd(4'd6, 2'd2, rv); chk("R4 foreign read silent", rv, 0);
    reg_rd(ME, 2'd2, rv); chk("R3 own read", rv, 8'hFF);

    // R5: self-clearing reset
    rst_cnt = 0;
    reg_wr(ME, 2'd0, 8'h05);
    chk("R5 one reset pulse", rst_cnt, 1);
    chk("R5 enable kept", wave_en, 1);
    reg_rd(ME, 2'd0, rv); chk("R5 reset bit reads 0", rv, 8'h04);

    // R6: control bits and trigger OR
    for (int k = 0; k < 8; k++) begin
      reg_wr(ME, 2'd0, 8'(k << 1));
      chk("R6 clk_dbl", clk_dbl, k & 1);
      chk("R6 wave_en", wave_en, (k >> 1) & 1);
      for (int t = 0; t < 2; t++) begin
        @(negedge clk); ttl_trig = t[0];
        repeat (2) @(negedge clk);
        chk("R6 trig", trig, ((k >> 2) & 1) | t);
      end
      ttl_trig = 0;
    end

    // R7: masked channel OR
    for (int m = 0; m < 8; m++) begin
      reg_wr(ME, 2'd0, 8'(m << 5));
      for (int c = 0; c < 8; c++) begin
        @(negedge clk); chan_bits = 3'(c);
        repeat (2) @(negedge clk);
        chk("R7 masked OR", aux_out, ((m & c) != 0) ? 1 : 0);
      end
    end
    chan_bits = 3'b111;
    reg_wr(ME, 2'd0, 8'h10);
    reg_wr(ME, 2'd2, 8'hA5);
    reg_rd(ME, 2'd2, rv);
    chk("R7 aux follows miso", aux_cap, 8'hA5);
    chk("R3 read under aux select", rv, 8'hA5);
    chan_bits = 0;

    // R8: addressed stream
    mem_wr(ME, 2'd1, 16'h0003, 4, 9);
    cmp_mem("R8 stream write");
    // R9: wrap and discarded upper address bits
    mem_wr(ME, 2'd2, 16'hFF0F, 3, 11);
    cmp_mem("R9 wrap");

    // R10: partial word discarded
    cs_lo();
    xfer(cmd(1, ME, 1, 2'd0), 8, r); xfer(8'h05, 8, r); xfer(8'h00, 8, r);
    xfer(8'h12, 8, r); xfer(8'h34, 8, r); xfer(8'h56, 8, r);
    cs_hi();
    exp_mem[0][5] = 16'h1234;
    cmp_mem("R10 partial word");
    cs_lo(); xfer(cmd(1, ME, 0, 2'd2), 8, r); xfer(8'h99, 4, r); cs_hi();
    chk("R10 partial byte", frame_sel, exp_frm);
    reg_wr(ME, 2'd2, 8'h3C);
    chk("R10 parser restarted", frame_sel, 8'h3C);

    // R11: channel 3 and memory reads
    mem_wr(ME, 2'd3, 16'h0000, 4, 13);
    cmp_mem("R11 channel 3 ignored");
    cs_lo(); xfer(cmd(0, ME, 1, 2'd0), 8, r); xfer(8'h00, 8, rv); cs_hi();
    chk("R11 memory read silent", rv, 0);

    // R12: one-clock read latency
    @(negedge clk); pb_addr = 0;
    @(negedge clk); pb_addr = 1;
    chk("R12 old data before edge", pb_data[15:0], exp_mem[0][0]);
    @(negedge clk);
    chk("R12 new data after edge", pb_data[15:0], exp_mem[0][1]);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule